// File: doc/BRIEF.md
# Shared-Line I2C Clock Synchronizer

This block produces the serial clock for one I2C master that sits on a clock line shared with other masters. The line is open-drain. The block never drives it high: it either pulls the line low or lets it go, and it watches the resolved line level to stay in step with every other master on the bus. Two 8-bit inputs set its own low period and its own high period, counted in system clock cycles.

The low phase starts when the block pulls the line low and counts its programmed low time. It then releases the line. While any other device still holds the line low, the block waits and does not count. High counting begins only when the synchronized line is seen to rise. If any master pulls the line low during the high count, the block gives up the rest of its high phase and starts a fresh low phase at once. The clock seen on the bus therefore has the longest low period and the shortest high period of all the masters taking part. On the first cycle of each high count the block raises a one-cycle strobe, so that a neighbouring data path knows when to sample the data line.

Top module: `scl_sync_master`

## Requirements
- R1: While reset is asserted and after it is released with enable low, `scl_pull` and `bit_strobe` are 0, and the internal line synchronizer holds the released (high) level.
- R2: When `enable` is sampled high in the idle state, `scl_pull` is 1 in the following cycle.
- R3: With enable held, each low phase keeps `scl_pull` at 1 for exactly max(`low_cycles`,1) consecutive cycles.
- R4: After a low phase `scl_pull` is 0 and stays 0, with no strobe, for as long as the line is held low by another device; once the line goes high, `scl_pull` returns to 1 exactly 3 + max(`high_cycles`,1) cycles later.
- R5: `bit_strobe` is 1 for exactly one cycle, on the first cycle of each high count, once per bit period, and `scl_pull` is 0 while it is high.
- R6: With no other master on the line, `scl_pull` stays 0 for exactly 3 + max(`high_cycles`,1) cycles between two low phases (three cycles of synchronizer and edge latency, then the high count).
- R7: If the synchronized line level is low during the high count, the high count is abandoned and a new low phase of full length max(`low_cycles`,1) starts.
- R8: `scl_line` passes through two synchronizing flops before any decision; a low level that appears on the line during the high count makes `scl_pull` read 1 three cycles later and not earlier.
- R9: When `enable` is sampled low, the next cycle has `scl_pull` = 0 and `bit_strobe` = 0, and both stay 0 while enable stays low.
- R10: A count value of 0 for either period is treated as a count of 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run the clock generator; low returns it to idle with the line released |
| low_cycles | input | CW (8) | Low-period length in clock cycles (0 means 1) |
| high_cycles | input | CW (8) | High-period length in clock cycles (0 means 1) |
| scl_line | input | 1 | Resolved level of the shared clock line, asynchronous |
| scl_pull | output | 1 | 1 = pull the clock line low, 0 = release it |
| bit_strobe | output | 1 | One-cycle pulse on the first cycle of each high count |

## Verification
The assertions assume that `low_cycles` and `high_cycles` change only while `enable` is low, and that `scl_line` is the wired-AND of this block's own release and every other master, so the line is never high while `scl_pull` is 1. The stimulus builds `scl_line` from `scl_pull` and a modelled second master in exactly that way, and it rewrites the period counts only after disabling the block. Line activity from the second master is driven on falling clock edges, including a one-cycle pulse during a high count and a long hold right after a release, so that the three-cycle reaction time is exercised and no half-cycle high is ever sampled.

// File: rtl/scl_sync_pkg.sv
package scl_sync_pkg;

    // Phase of the clock generator
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_LOW    = 2'd1,
        PH_WAITHI = 2'd2,
        PH_HIGH   = 2'd3
    } scl_phase_e;

endpackage

// File: rtl/scl_sync_meta.sv
module scl_sync_meta #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic lvl,
    output logic rise
);

    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } meta_t;

    meta_t m_d, m_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb begin
                m_d.chain = async_in;
                m_d.prev  = m_q.chain[0];
            end
        end else begin : g_multi
            always_comb begin
                m_d.chain = {m_q.chain[STAGES-2:0], async_in};
                m_d.prev  = m_q.chain[STAGES-1];
            end
        end
    endgenerate

    // Released line reads high, so the chain resets to ones
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_q.chain <= '1;
            m_q.prev  <= 1'b1;
        end else begin
            m_q <= m_d;
        end
    end

    assign lvl  = m_q.chain[STAGES-1];
    assign rise = m_q.chain[STAGES-1] & ~m_q.prev;

endmodule

// File: rtl/scl_sync_fsm.sv
module scl_sync_fsm
    import scl_sync_pkg::*;
#(
    parameter int unsigned CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic [CW-1:0] low_cycles,
    input  logic [CW-1:0] high_cycles,
    input  logic          bus_lvl,
    input  logic          bus_rise,
    output logic          pull,
    output logic          strobe
);

    localparam int unsigned EW = CW + 1;

    typedef struct packed {
        scl_phase_e    phase;
        logic [CW-1:0] cnt;
        logic          strobe;
    } fsm_t;

    fsm_t s_d, s_q;

    logic [EW-1:0] low_lim, high_lim, cnt_inc;
    logic          low_done, high_done;

    // A programmed zero behaves as one cycle
    always_comb begin
        low_lim   = (low_cycles  == '0) ? EW'(1) : {1'b0, low_cycles};
        high_lim  = (high_cycles == '0) ? EW'(1) : {1'b0, high_cycles};
        cnt_inc   = {1'b0, s_q.cnt} + EW'(1);
        low_done  = (cnt_inc >= low_lim);
        high_done = (cnt_inc >= high_lim);
    end

    always_comb begin
        s_d        = s_q;
        s_d.strobe = 1'b0;
        if (!enable) begin
            s_d.phase = PH_IDLE;
            s_d.cnt   = '0;
        end else begin
            unique case (s_q.phase)
                PH_IDLE: begin
                    s_d.phase = PH_LOW;
                    s_d.cnt   = '0;
                end
                PH_LOW: begin
                    if (low_done) begin
                        s_d.phase = PH_WAITHI;
                        s_d.cnt   = '0;
                    end else begin
                        s_d.cnt = cnt_inc[CW-1:0];
                    end
                end
                PH_WAITHI: begin
                    if (bus_rise) begin
                        s_d.phase  = PH_HIGH;
                        s_d.cnt    = '0;
                        s_d.strobe = 1'b1;
                    end
                end
                PH_HIGH: begin
                    if (!bus_lvl || high_done) begin
                        s_d.phase = PH_LOW;
                        s_d.cnt   = '0;
                    end else begin
                        s_d.cnt = cnt_inc[CW-1:0];
                    end
                end
                default: begin
                    s_d.phase = PH_IDLE;
                    s_d.cnt   = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.phase  <= PH_IDLE;
            s_q.cnt    <= '0;
            s_q.strobe <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign pull   = (s_q.phase == PH_LOW);
    assign strobe = s_q.strobe;

endmodule

// File: rtl/scl_sync_master.sv
module scl_sync_master #(
    parameter int unsigned CW          = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic [CW-1:0] low_cycles,
    input  logic [CW-1:0] high_cycles,
    input  logic          scl_line,
    output logic          scl_pull,
    output logic          bit_strobe
);

    logic line_lvl;
    logic line_rise;

    scl_sync_meta #(
        .STAGES(SYNC_STAGES)
    ) u_meta (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_in(scl_line),
        .lvl     (line_lvl),
        .rise    (line_rise)
    );

    scl_sync_fsm #(
        .CW(CW)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .low_cycles (low_cycles),
        .high_cycles(high_cycles),
        .bus_lvl    (line_lvl),
        .bus_rise   (line_rise),
        .pull       (scl_pull),
        .strobe     (bit_strobe)
    );

endmodule

// File: rtl/scl_sync_master_chk.sv
module scl_sync_master_chk #(
    parameter int unsigned CW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          enable,
    input logic [CW-1:0] low_cycles,
    input logic          scl_pull,
    input logic          bit_strobe
);

    // R9
    disable_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!scl_pull && !bit_strobe));

    // R2
    enable_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(enable) |=> scl_pull);

    // R5
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_strobe |=> !bit_strobe);

    // R5
    strobe_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_strobe |-> !scl_pull);

    // R3
    low_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(scl_pull) && enable && (low_cycles > CW'(1))) |=> scl_pull);

endmodule

bind scl_sync_master scl_sync_master_chk #(.CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .low_cycles(low_cycles),
    .scl_pull  (scl_pull),
    .bit_strobe(bit_strobe)
);

// File: tb/scl_sync_master_bench.sv
module scl_sync_master_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic       other_low = 1'b0;
    logic [7:0] low_cycles = 8'd4;
    logic [7:0] high_cycles = 8'd3;
    logic       scl_pull, bit_strobe;
    wire        scl_line;

    int  n_cmp = 0;
    int  n_bad = 0;
    int  cyc   = 0;
    bit  done  = 1'b0;

    // wired-AND line: this master plus a modelled second master
    assign scl_line = ~(scl_pull | other_low);

    always #4 clk = ~clk;

    scl_sync_master u_scl_sync_master (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .low_cycles (low_cycles),
        .high_cycles(high_cycles),
        .scl_line   (scl_line),
        .scl_pull   (scl_pull),
        .bit_strobe (bit_strobe)
    );

    // ---------------- behavioural reference ----------------
    // mode: 0 idle, 1 pulling, 2 waiting for line, 3 counting high
    int mode = 0;
    int elapsed = 0;
    bit m_strobe = 1'b0;
    bit line_hist [$] = '{1'b1, 1'b1};   // [0] newest sample
    bit seen_prev = 1'b1;

    function automatic int eff(input logic [7:0] v);
        return (v == 8'd0) ? 1 : int'(v);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode = 0; elapsed = 0; m_strobe = 1'b0;
            line_hist = '{1'b1, 1'b1}; seen_prev = 1'b1;
        end else begin
            bit seen, went_up;
            seen    = line_hist[1];
            went_up = seen && !seen_prev;
            m_strobe = 1'b0;
            if (!enable) begin
                mode = 0; elapsed = 0;
            end else if (mode == 0) begin
                mode = 1; elapsed = 0;
            end else if (mode == 1) begin
                elapsed++;
                if (elapsed >= eff(low_cycles)) begin mode = 2; elapsed = 0; end
            end else if (mode == 2) begin
                if (went_up) begin mode = 3; elapsed = 0; m_strobe = 1'b1; end
            end else begin
                elapsed++;
                if (!seen || elapsed >= eff(high_cycles)) begin mode = 1; elapsed = 0; end
            end
            seen_prev = seen;
            line_hist.push_front(scl_line);
            void'(line_hist.pop_back());
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            bit exp_pull;
            exp_pull = (mode == 1);
            n_cmp++;
            if (scl_pull !== exp_pull || bit_strobe !== m_strobe) begin
                n_bad++;
                $display("FAIL %s model compare t=%0t: pull=%0b strobe=%0b expected pull=%0b strobe=%0b",
                         (mode == 0) ? "R9" : (mode == 1) ? "R3" : (mode == 2) ? "R4" : "R7",
                         $time, scl_pull, bit_strobe, exp_pull, m_strobe);
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_pull(input logic v);
        logic p;
        p = scl_pull;
        forever begin
            @(negedge clk);
            if (scl_pull == v && p != v) break;
            p = scl_pull;
        end
    endtask

    // from a rising pull: low run, then released run, with strobes seen in it
    task automatic measure(output int lo, output int gap, output int st);
        wait_pull(1'b1);
        lo = 0; gap = 0; st = 0;
        while (scl_pull) begin lo++; @(negedge clk); end
        while (!scl_pull) begin gap++; if (bit_strobe) st++; @(negedge clk); end
    endtask

    task automatic reprogram(input logic [7:0] lo_v, input logic [7:0] hi_v);
        enable = 1'b0;
        tick(2);
        low_cycles = lo_v; high_cycles = hi_v;
        enable = 1'b1;
    endtask

    // ---------------- watchdog ----------------
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cyc, 100000);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        int lo, gap, st, dly;
        tick(3);
        chk("R1 pull in reset", scl_pull, 0);
        chk("R1 strobe in reset", bit_strobe, 0);
        rst_n = 1'b1;
        tick(3);
        chk("R1 pull after reset", scl_pull, 0);
        chk("R1 strobe after reset", bit_strobe, 0);

        // R2: start from idle
        enable = 1'b1;
        @(negedge clk);
        chk("R2 pull one cycle after enable", scl_pull, 1);

        // R3 R5 R6 uncontested, L=4 H=3
        measure(lo, gap, st);
        chk("R3 low run L=4", lo, 4);
        chk("R6 released run H=3", gap, 6);
        chk("R5 strobes per bit", st, 1);

        // second setting L=7 H=5
        reprogram(8'd7, 8'd5);
        measure(lo, gap, st);
        chk("R3 low run L=7", lo, 7);
        chk("R6 released run H=5", gap, 8);
        chk("R5 strobes per bit H=5", st, 1);

        // R9: disable mid low phase
        wait_pull(1'b1);
        tick(1);
        enable = 1'b0;
        @(negedge clk);
        chk("R9 pull after disable", scl_pull, 0);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            chk("R9 pull stays released", scl_pull, 0);
            chk("R9 no strobe while disabled", bit_strobe, 0);
        end

        // R10: zero counts
        reprogram(8'd0, 8'd0);
        measure(lo, gap, st);
        chk("R10 zero low count", lo, 1);
        chk("R10 zero high count", gap, 4);
        chk("R10 strobe per bit", st, 1);

        // R4: second master stretches the low phase
        reprogram(8'd4, 8'd3);
        wait_pull(1'b1);
        wait_pull(1'b0);
        other_low = 1'b1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            chk("R4 pull released during stretch", scl_pull, 0);
            chk("R4 no strobe during stretch", bit_strobe, 0);
        end
        other_low = 1'b0;
        dly = 0;
        do begin @(negedge clk); dly++; end while (!scl_pull);
        chk("R4 resume delay after line release", dly, 6);
        measure(lo, gap, st);
        chk("R3 low run after stretch", lo, 4);

        // R7 R8: second master cuts the high phase short
        reprogram(8'd4, 8'd40);
        do @(negedge clk); while (!bit_strobe);
        tick(5);
        other_low = 1'b1;
        @(negedge clk);
        other_low = 1'b0;
        chk("R8 no reaction after one cycle", scl_pull, 0);
        @(negedge clk);
        chk("R8 no reaction after two cycles", scl_pull, 0);
        @(negedge clk);
        chk("R7 pull after line low in high count", scl_pull, 1);
        lo = 0;
        while (scl_pull) begin lo++; @(negedge clk); end
        chk("R7 fresh full low count", lo, 4);

        enable = 1'b0;
        tick(5);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule